// File: doc/BRIEF.md
# Triple-Slot Frame Manager

This block sits between a streaming producer and a frame-oriented consumer. Samples arrive on an AXI4-Stream style input and are written into one of three on-chip frame slots. A beat with `s_tlast` set ends a frame. The consumer is handed whole frames only. It reads any word of the current frame by address and signals when it has finished with that frame.

The three slots take three roles: write, pending and read. These roles rotate so that the input is never back-pressured. The input ready is always high, so a consumer that takes longer than one frame period costs no input beats. If a newer frame completes while an older one is still waiting, the older waiting frame is discarded and an overwrite counter records the loss. The consumer always receives frames in the order they completed, each tagged with a sequence number and its stored length. The storage cost is three frames, which is half as much again as a two-bank arrangement.

Top module: `tribuf_frame_mgr`

## Requirements
- R1: After reset, `frame_valid`, `pending_valid` and `overwrite_count` are 0, `s_tready` is 1, and the first completed frame carries sequence number 0.
- R2: `s_tready` is 1 in every cycle after reset. Every beat with `s_tvalid` high is accepted.
- R3: When a frame completes while no frame is held by the consumer, `frame_valid` is 1 in the cycle after the `s_tlast` beat. `frame_len` then gives the number of stored words. `rd_data` returns the word at `rd_addr` one clock after the address is presented.
- R4: When a frame completes while the consumer holds a frame, the new frame waits and `pending_valid` becomes 1 in the cycle after the `s_tlast` beat.
- R5: When a frame completes while a frame is already waiting, the waiting frame is dropped and the new frame takes its place. `overwrite_count` increases by one and saturates at its all-ones value.
- R6: A `frame_done` pulse while a frame is waiting makes the waiting frame the consumer's frame in the next cycle, and `pending_valid` falls.
- R7: A `frame_done` pulse with nothing waiting makes `frame_valid` fall in the next cycle.
- R8: When `frame_done` and a frame completion fall in the same cycle, the older frame goes to the consumer first. If a frame was waiting, it becomes the consumer's frame and the completing frame becomes the waiting one, with no overwrite. If nothing was waiting, the completing frame goes straight to the consumer.
- R9: Completed frames are numbered consecutively (modulo 2^SEQ_W). The `frame_seq` values the consumer sees only ever move forward.
- R10: `frame_done` is ignored while `frame_valid` is 0.
- R11: Beats past FRAME_LEN words in one frame are not stored. `frame_len` saturates at FRAME_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DATA_W | Stream sample |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of a frame |
| s_tready | output | 1 | Stream ready, always high |
| rd_addr | input | ADDR_W | Word address in the consumer's frame |
| rd_data | output | DATA_W | Word read, one cycle after the address |
| frame_valid | output | 1 | Consumer holds a frame |
| frame_len | output | LEN_W | Stored word count of the consumer's frame |
| frame_seq | output | SEQ_W | Sequence number of the consumer's frame |
| frame_done | input | 1 | Consumer releases its frame |
| pending_valid | output | 1 | A completed frame is waiting |
| overwrite_count | output | OVF_W | Waiting frames dropped by newer ones |

## Verification
The stimulus starts with isolated frames, which show the direct handover to an idle consumer apart from the wait in the pending slot. Next come repeated completions with no release in between, which show the overwrite path and counter saturation, and release pulses while idle, which must leave the state unchanged. An over-long frame and a release that coincides with a completion test truncation and same-cycle ordering. A long pseudo-random mix of gapped beats, frame lengths, release pulses and read addresses then compares every output against a queue-based model in every cycle.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
   localparam int NUM_SLOTS = 3;
   typedef logic [1:0] slot_idx_t;
endpackage

// File: rtl/tbm_slot_bank.sv
module tbm_slot_bank #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/tbm_fill_ctrl.sv
module tbm_fill_ctrl #(
   parameter int FRAME_LEN = 16,
   localparam int ADDR_W = $clog2(FRAME_LEN),
   localparam int LEN_W  = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              last,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic              complete,
   output logic [LEN_W-1:0]  complete_len
);
   localparam logic [LEN_W-1:0] FULL = LEN_W'(FRAME_LEN);

   logic [LEN_W-1:0] cnt_q;
   logic             room;

   assign room         = (cnt_q < FULL);
   assign we           = beat && room;
   assign waddr        = cnt_q[ADDR_W-1:0];
   assign complete     = beat && last;
   assign complete_len = room ? cnt_q + 1'b1 : FULL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (beat) begin
         if (last)         cnt_q <= '0;
         else if (room)    cnt_q <= cnt_q + 1'b1;
      end
   end

   // R11: the fill count never passes the slot depth
   assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R11: a beat beyond capacity leaves the count where it was
   assert_fill_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !last && !room) |=> cnt_q == FULL);
endmodule

// File: rtl/tbm_role_ctrl.sv
module tbm_role_ctrl
   import tbm_pkg::*;
#(
   parameter int LEN_W        = 5,
   parameter int SEQ_W        = 8,
   parameter int OVF_W        = 8,
   parameter bit OVF_SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             complete,
   input  logic [LEN_W-1:0] complete_len,
   input  logic             done,
   output slot_idx_t        wr_idx,
   output slot_idx_t        rd_idx,
   output logic             rd_valid,
   output logic             pend_valid,
   output logic [LEN_W-1:0] rd_len,
   output logic [SEQ_W-1:0] rd_seq,
   output logic [OVF_W-1:0] ovf_count
);
   slot_idx_t        wr_q, pend_q, rd_q, wr_n, pend_n, rd_n;
   logic             rv_q, pv_q, rv_n, pv_n, bump;
   logic [SEQ_W-1:0] seq_cnt_q;
   logic [SEQ_W-1:0] seq_q [NUM_SLOTS];
   logic [LEN_W-1:0] len_q [NUM_SLOTS];
   logic [OVF_W-1:0] ovf_q, ovf_next;
   logic             done_eff;

   assign done_eff = done && rv_q;

   generate
      if (OVF_SATURATE) begin : g_ovf_sat
         assign ovf_next = (&ovf_q) ? ovf_q : ovf_q + 1'b1;
      end else begin : g_ovf_wrap
         assign ovf_next = ovf_q + 1'b1;
      end
   endgenerate

   always_comb begin
      wr_n   = wr_q;
      pend_n = pend_q;
      rd_n   = rd_q;
      rv_n   = rv_q;
      pv_n   = pv_q;
      bump   = 1'b0;
      if (done_eff && complete) begin
         if (pv_q) begin
            rd_n   = pend_q;
            pend_n = wr_q;
            wr_n   = rd_q;
         end else begin
            rd_n = wr_q;
            wr_n = rd_q;
         end
      end else if (done_eff) begin
         if (pv_q) begin
            rd_n   = pend_q;
            pend_n = rd_q;
            pv_n   = 1'b0;
         end else begin
            rv_n = 1'b0;
         end
      end else if (complete) begin
         if (!rv_q) begin
            rd_n = wr_q;
            wr_n = rd_q;
            rv_n = 1'b1;
         end else begin
            pend_n = wr_q;
            wr_n   = pend_q;
            pv_n   = 1'b1;
            bump   = pv_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= 2'd0;
         pend_q    <= 2'd1;
         rd_q      <= 2'd2;
         rv_q      <= 1'b0;
         pv_q      <= 1'b0;
         seq_cnt_q <= '0;
         ovf_q     <= '0;
         for (int i = 0; i < NUM_SLOTS; i++) begin
            seq_q[i] <= '0;
            len_q[i] <= '0;
         end
      end else begin
         wr_q   <= wr_n;
         pend_q <= pend_n;
         rd_q   <= rd_n;
         rv_q   <= rv_n;
         pv_q   <= pv_n;
         if (bump) ovf_q <= ovf_next;
         if (complete) begin
            seq_q[wr_q] <= seq_cnt_q;
            len_q[wr_q] <= complete_len;
            seq_cnt_q   <= seq_cnt_q + 1'b1;
         end
      end
   end

   assign wr_idx     = wr_q;
   assign rd_idx     = rd_q;
   assign rd_valid   = rv_q;
   assign pend_valid = pv_q;
   assign rd_len     = len_q[rd_q];
   assign rd_seq     = seq_q[rd_q];
   assign ovf_count  = ovf_q;

   // R8: the three roles always name three different slots
   assert_roles_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q != rd_q && wr_q != pend_q && rd_q != pend_q &&
      wr_q != 2'd3 && rd_q != 2'd3 && pend_q != 2'd3);
   // R4: a frame can only wait while the consumer holds one
   assert_pend_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pv_q |-> rv_q);
   // R5: a completion over a waiting frame counts one overwrite
   assert_overwrite_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && rv_q && pv_q && !done && !(&ovf_q)) |=> ovf_q == $past(ovf_q) + 1'b1);
   // R6: a release promotes the waiting slot
   assert_promote_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rv_q && pv_q && !complete) |=> (rd_q == $past(pend_q)) && !pv_q);
   // R10: a release with no frame held changes nothing
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rv_q && !complete) |=> $stable(rd_q) && $stable(wr_q) && !rv_q);
   // R9: the consumer's sequence number only moves forward
   assert_seq_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rv_q && $past(rv_q) && rd_seq != $past(rd_seq)) |->
      !SEQ_W'((rd_seq - $past(rd_seq)) >> (SEQ_W - 1)));
endmodule

// File: rtl/tribuf_frame_mgr.sv
module tribuf_frame_mgr
   import tbm_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int FRAME_LEN    = 16,
   parameter int SEQ_W        = 8,
   parameter int OVF_W        = 8,
   parameter bit OVF_SATURATE = 1'b1,
   localparam int ADDR_W = $clog2(FRAME_LEN),
   localparam int LEN_W  = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   input  logic              s_tlast,
   output logic              s_tready,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              frame_valid,
   output logic [LEN_W-1:0]  frame_len,
   output logic [SEQ_W-1:0]  frame_seq,
   input  logic              frame_done,
   output logic              pending_valid,
   output logic [OVF_W-1:0]  overwrite_count
);
   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("FRAME_LEN must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (SEQ_W < 2) begin : g_bad_seq
         $error("SEQ_W must be at least 2");
      end
      if (OVF_W < 1) begin : g_bad_ovf
         $error("OVF_W must be at least 1");
      end
   endgenerate

   logic              beat, we, complete;
   logic [ADDR_W-1:0] waddr;
   logic [LEN_W-1:0]  complete_len;
   slot_idx_t         wr_idx, rd_idx, rd_sel_q;
   logic [DATA_W-1:0] bank_q [NUM_SLOTS];

   assign s_tready = 1'b1;
   assign beat     = s_tvalid;

   tbm_fill_ctrl #(.FRAME_LEN(FRAME_LEN)) u_fill (
      .clk          (clk),
      .rst_n        (rst_n),
      .beat         (beat),
      .last         (s_tlast),
      .we           (we),
      .waddr        (waddr),
      .complete     (complete),
      .complete_len (complete_len)
   );

   tbm_role_ctrl #(
      .LEN_W        (LEN_W),
      .SEQ_W        (SEQ_W),
      .OVF_W        (OVF_W),
      .OVF_SATURATE (OVF_SATURATE)
   ) u_roles (
      .clk          (clk),
      .rst_n        (rst_n),
      .complete     (complete),
      .complete_len (complete_len),
      .done         (frame_done),
      .wr_idx       (wr_idx),
      .rd_idx       (rd_idx),
      .rd_valid     (frame_valid),
      .pend_valid   (pending_valid),
      .rd_len       (frame_len),
      .rd_seq       (frame_seq),
      .ovf_count    (overwrite_count)
   );

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bank
         tbm_slot_bank #(.DATA_W(DATA_W), .DEPTH(FRAME_LEN)) u_bank (
            .clk   (clk),
            .we    (we && (wr_idx == slot_idx_t'(g))),
            .waddr (waddr),
            .wdata (s_tdata),
            .raddr (rd_addr),
            .rdata (bank_q[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_sel_q <= 2'd0;
      else        rd_sel_q <= rd_idx;
   end

   assign rd_data = (rd_sel_q == 2'd3) ? '0 : bank_q[rd_sel_q];

   // R3: a completion with an idle consumer hands the frame over next cycle
   assert_direct_handoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && !frame_valid) |=> frame_valid && !pending_valid);
   // R7: a release with nothing waiting and no completion empties the consumer
   assert_release_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_valid && !pending_valid && !complete) |=> !frame_valid);
endmodule

// File: tb/tribuf_frame_mgr_bench.sv
module tribuf_frame_mgr_bench;
   localparam int DW = 32, FL = 8, SW = 8, OW = 3;
   localparam int AW = $clog2(FL), LW = $clog2(FL + 1);

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [DW-1:0] s_tdata = '0;
   logic          s_tvalid = 1'b0, s_tlast = 1'b0, frame_done = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          s_tready, frame_valid, pending_valid;
   logic [DW-1:0] rd_data;
   logic [LW-1:0] frame_len;
   logic [SW-1:0] frame_seq;
   logic [OW-1:0] overwrite_count;

   always #2 clk = ~clk;

   tribuf_frame_mgr #(.DATA_W(DW), .FRAME_LEN(FL), .SEQ_W(SW), .OVF_W(OW)) u_tribuf_frame_mgr (
      .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
      .s_tready(s_tready), .rd_addr(rd_addr), .rd_data(rd_data), .frame_valid(frame_valid),
      .frame_len(frame_len), .frame_seq(frame_seq), .frame_done(frame_done),
      .pending_valid(pending_valid), .overwrite_count(overwrite_count));

   int checks = 0, failures = 0;
   string tag = "R1";

   // reference model
   logic [DW-1:0] m_wq[$], m_rd[$], m_pd[$];
   int  m_rseq = 0, m_pseq = 0, m_seqc = 0, m_ovf = 0;
   bit  m_rv = 0, m_pv = 0;

   task automatic chk(string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_state();
      chk("R2 s_tready", s_tready, 1);
      chk("frame_valid", frame_valid, m_rv);
      chk("pending_valid", pending_valid, m_pv);
      chk("overwrite_count", overwrite_count, m_ovf);
      if (m_rv) begin
         chk("frame_seq", frame_seq, m_rseq % (1 << SW));
         chk("frame_len", frame_len, m_rd.size());
      end
   endtask

   task automatic cyc(bit v, logic [DW-1:0] d, bit l, bit dn, int a);
      logic [DW-1:0] exp_rd;
      bit            rd_chk, cmp, dn_eff;
      logic [DW-1:0] newf[$];
      int            newseq;
      s_tvalid = v; s_tdata = d; s_tlast = l; frame_done = dn; rd_addr = AW'(a);
      rd_chk = m_rv && (a < m_rd.size());
      exp_rd = rd_chk ? m_rd[a] : '0;
      @(posedge clk);
      #1;
      cmp = v && l;
      dn_eff = dn && m_rv;
      if (v && m_wq.size() < FL) m_wq.push_back(d);
      if (cmp) begin
         newf = m_wq; newseq = m_seqc; m_seqc++; m_wq = {};
      end
      if (dn_eff) begin
         if (m_pv) begin m_rd = m_pd; m_rseq = m_pseq; m_pv = 0; end
         else m_rv = 0;
      end
      if (cmp) begin
         if (!m_rv) begin m_rd = newf; m_rseq = newseq; m_rv = 1; end
         else begin
            if (m_pv && m_ovf < (1 << OW) - 1) m_ovf++;
            m_pd = newf; m_pseq = newseq; m_pv = 1;
         end
      end
      if (rd_chk) chk("rd_data", rd_data, exp_rd);
      compare_state();
      s_tvalid = 0; s_tlast = 0; frame_done = 0;
   endtask

   task automatic send(int n, logic [DW-1:0] base);
      for (int i = 0; i < n; i++) cyc(1, base + DW'(i), i == n - 1, 0, 0);
   endtask

   task automatic read_all();
      for (int a = 0; a < FL; a++) cyc(0, '0, 0, 0, a);
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired at check %0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      int flen, fpos;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tag = "R1"; compare_state();
      cyc(0, '0, 0, 0, 0);

      tag = "R3"; send(4, 32'hA000_0000); read_all();
      tag = "R4"; send(5, 32'hB000_0000); read_all();
      tag = "R5"; send(3, 32'hC000_0000); read_all();
      tag = "R6"; cyc(0, '0, 0, 1, 0); read_all();
      tag = "R9"; chk("R9 seq after skip", frame_seq, 2);
      tag = "R7"; cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 0, 0);
      tag = "R10"; cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 1, 3);
      chk("R10 no frame after idle release", frame_valid, 0);

      tag = "R11"; send(11, 32'hD000_0000); read_all();
      chk("R11 saturated length", frame_len, FL);

      tag = "R8"; send(2, 32'hE000_0000);
      send(2, 32'hE100_0000);
      for (int i = 0; i < 2; i++) cyc(1, 32'hE200_0000 + DW'(i), i == 1, i == 1, i);
      read_all();
      cyc(1, 32'hE300_0000, 1, 1, 0); read_all();

      tag = "R5"; for (int k = 0; k < 9; k++) send(2, 32'hF000_0000 + DW'(k << 8));
      chk("R5 saturated overwrite count", overwrite_count, (1 << OW) - 1);
      cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 1, 0);

      tag = "R9";
      lf = 16'hACE1; flen = 3; fpos = 0;
      for (int c = 0; c < 2000; c++) begin
         bit v, dn;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         v  = lf[0] | lf[1];
         dn = (lf[5:3] == 3'd0);
         cyc(v, {16'h5A00, lf}, v && (fpos == flen - 1), dn, int'(lf[8:6]));
         if (v) begin
            if (fpos == flen - 1) begin fpos = 0; flen = 1 + int'(lf[11:9]) + int'(lf[2]); end
            else fpos++;
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule